// File: doc/BRIEF.md
# Next-PC Computation Unit

This block holds the program counter of a single-cycle 32-bit RISC core and works out the address the core fetches from next. Each cycle it forms four candidates from the current PC, the instruction word and the value read from the base register. The first is the sequential address. The second is a word-scaled relative branch target. The third is an absolute jump target that keeps the current 256 MB region. The fourth is a register-supplied target. A two-bit select from the control decoder picks one of the four.

The selected address is shown combinationally on `pc_next` and is loaded into the PC register at the rising clock edge when the enable is high. The sequential address is also driven out as the link value, which a jump-and-link writes back into the register file. The upstream decoder evaluates the branch condition and turns a not-taken branch into a sequential select. There is no delay slot and no exception redirect.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` holds the reset vector (parameter `RESET_VEC`, default 0x00000000), and it keeps that value after release until an enabled clock edge.
- R2: `link_val` always equals `pc_q` + 4, modulo 2^32.
- R3: With `pc_sel` = 2'd0 (sequential), `pc_next` is `pc_q` + 4, whatever `instr` and `rs_val` hold.
- R4: With `pc_sel` = 2'd1 (relative branch), `pc_next` is `pc_q` + 4 plus `instr[15:0]` sign-extended and shifted left by 2. This reaches backward and forward by about 128 KB.
- R5: With `pc_sel` = 2'd3 (region jump), `pc_next` is `{pc_q[31:28], instr[25:0], 2'b00}`. The region bits come from the current PC, and `instr[31:26]` has no effect.
- R6: With `pc_sel` = 2'd2 (register target), `pc_next` equals `rs_val` bit for bit, including its two low bits.
- R7: At a rising clock edge with `en` high, `pc_q` takes the value `pc_next` had before the edge. With `en` low, `pc_q` keeps its value.
- R8: All address sums wrap modulo 2^32, with no saturation and no carry out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| en | input | 1 | PC update enable |
| pc_sel | input | 2 | Next-PC source: 0 sequential, 1 branch, 2 register, 3 region jump |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | Base register value for register-indirect targets |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Selected next address |
| link_val | output | 32 | Return address, current PC plus 4 |

## Verification
Branch offsets cover a small forward step, minus one word and both extremes of the 16-bit field. Together they separate a correct sign extension and word scaling from a zero-extended or unscaled offset, and confirm that the base is PC+4 rather than PC. Region jumps run at a region boundary, in the top region and with opcode bits set. These show whether the kept upper bits come from the current PC and whether the opcode leaks into the target. Register targets with odd low bits, wrap-around at the top of the address space, and a held enable with a non-sequential select complete the patterns.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    PCSEL_SEQ      = 2'd0,
    PCSEL_BRANCH   = 2'd1,
    PCSEL_INDIRECT = 2'd2,
    PCSEL_REGION   = 2'd3
  } pcsel_e;
endpackage

// File: rtl/npc_seq_adder.sv
module npc_seq_adder #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] seq_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_comb begin
    seq_o = pc_i + STEP_V;
  end
endmodule

// File: rtl/npc_branch_target.sv
module npc_branch_target #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFF_W    = 16,
  parameter int unsigned ALIGN_SH = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] tgt_o
);
  localparam int unsigned EXT_W = ADDR_W - OFF_W - ALIGN_SH;

  logic [ADDR_W-1:0] disp;

  always_comb begin
    disp  = {{EXT_W{off_i[OFF_W-1]}}, off_i, {ALIGN_SH{1'b0}}};
    tgt_o = base_i + disp;
  end
endmodule

// File: rtl/npc_region_target.sv
module npc_region_target #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned TGT_W    = 26,
  parameter int unsigned ALIGN_SH = 2
) (
  input  logic [ADDR_W-TGT_W-ALIGN_SH-1:0] region_i,
  input  logic [TGT_W-1:0]                 field_i,
  output logic [ADDR_W-1:0]                tgt_o
);
  always_comb begin
    tgt_o = {region_i, field_i, {ALIGN_SH{1'b0}}};
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int unsigned        ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]  RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] nxt_i,
  output logic [ADDR_W-1:0] q_o
);
  logic [ADDR_W-1:0] d;

  always_comb begin
    d = q_o;
    if (en_i) d = nxt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= RESET_VEC;
    else        q_o <= d;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        INSTR_W   = 32,
  parameter int unsigned        OFF_W     = 16,
  parameter int unsigned        TGT_W     = 26,
  parameter int unsigned        ALIGN_SH  = 2,
  parameter logic [ADDR_W-1:0]  RESET_VEC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [1:0]         pc_sel,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  rs_val,
  output logic [ADDR_W-1:0]  pc_q,
  output logic [ADDR_W-1:0]  pc_next,
  output logic [ADDR_W-1:0]  link_val
);
  import npc_pkg::*;

  localparam int unsigned STEP     = 1 << ALIGN_SH;
  localparam int unsigned REGION_W = ADDR_W - TGT_W - ALIGN_SH;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] br_pc;
  logic [ADDR_W-1:0] region_pc;
  logic              unused_opc;

  // Opcode bits steer the upstream decoder only.
  assign unused_opc = ^instr[INSTR_W-1:TGT_W];

  npc_seq_adder #(.ADDR_W(ADDR_W), .STEP(STEP)) u_seq (
    .pc_i  (pc_q),
    .seq_o (seq_pc)
  );

  npc_branch_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALIGN_SH(ALIGN_SH)) u_br (
    .base_i (seq_pc),
    .off_i  (instr[OFF_W-1:0]),
    .tgt_o  (br_pc)
  );

  npc_region_target #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .ALIGN_SH(ALIGN_SH)) u_rgn (
    .region_i (pc_q[ADDR_W-1 -: REGION_W]),
    .field_i  (instr[TGT_W-1:0]),
    .tgt_o    (region_pc)
  );

  always_comb begin
    unique case (pcsel_e'(pc_sel))
      PCSEL_BRANCH:   pc_next = br_pc;
      PCSEL_INDIRECT: pc_next = rs_val;
      PCSEL_REGION:   pc_next = region_pc;
      default:        pc_next = seq_pc;
    endcase
    link_val = seq_pc;
  end

  npc_pc_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en),
    .nxt_i (pc_next),
    .q_o   (pc_q)
  );
endmodule

// File: rtl/npc_unit_checker.sv
module npc_unit_checker #(
  parameter int unsigned        ADDR_W    = 32,
  parameter int unsigned        INSTR_W   = 32,
  parameter int unsigned        TGT_W     = 26,
  parameter int unsigned        ALIGN_SH  = 2,
  parameter logic [ADDR_W-1:0]  RESET_VEC = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic [1:0]         pc_sel,
  input logic [INSTR_W-1:0] instr,
  input logic [ADDR_W-1:0]  rs_val,
  input logic [ADDR_W-1:0]  pc_q,
  input logic [ADDR_W-1:0]  pc_next,
  input logic [ADDR_W-1:0]  link_val
);
  localparam int unsigned REGION_W = ADDR_W - TGT_W - ALIGN_SH;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(1 << ALIGN_SH);

  // R1: register sits at the reset vector while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_vec_r1: assert (pc_q == RESET_VEC)
        else $error("pc not at reset vector during reset");
    end
  end

  p_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    link_val == pc_q + STEP_V);

  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel == 2'd0 |-> pc_next == link_val);

  p_branch_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel == 2'd1 |-> pc_next[ALIGN_SH-1:0] == pc_q[ALIGN_SH-1:0]);

  p_region_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel == 2'd3 |-> (pc_next[ADDR_W-1 -: REGION_W] == pc_q[ADDR_W-1 -: REGION_W]
                        && pc_next[ALIGN_SH-1:0] == '0));

  p_indirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel == 2'd2 |-> pc_next == rs_val);

  p_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> pc_q == $past(pc_next));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pc_q));

  logic unused_chk;
  assign unused_chk = ^instr;
endmodule

bind npc_unit npc_unit_checker #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .TGT_W(TGT_W),
  .ALIGN_SH(ALIGN_SH), .RESET_VEC(RESET_VEC)
) u_npc_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pc_sel(pc_sel), .instr(instr),
  .rs_val(rs_val), .pc_q(pc_q), .pc_next(pc_next), .link_val(link_val)
);

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [1:0]  pc_sel;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] pc_q;
  logic [31:0] pc_next;
  logic [31:0] link_val;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .pc_sel(pc_sel), .instr(instr),
    .rs_val(rs_val), .pc_q(pc_q), .pc_next(pc_next), .link_val(link_val)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pc(input logic [31:0] v);
    pc_sel = 2'd2; rs_val = v; en = 1'b1; instr = 32'h0;
    #0.5;
    chk("R6 register target", pc_next, v);
    step();
    chk("R7 load via register target", pc_q, v);
  endtask

  task automatic t_reset();
    rst_n = 1'b1; en = 1'b0; pc_sel = 2'd0; instr = '0; rs_val = '0;
    #2 rst_n = 1'b0;
    en = 1'b1; pc_sel = 2'd2; rs_val = 32'hDEAD_BEEC;
    step();
    chk("R1 pc during reset", pc_q, 32'h0);
    en = 1'b0;
    rst_n = 1'b1;
    step();
    chk("R1 pc after release", pc_q, 32'h0);
    chk("R2 link after reset", link_val, 32'h4);
  endtask

  task automatic t_sequential();
    set_pc(32'h0000_0100);
    pc_sel = 2'd0; instr = 32'hFFFF_FFFF; rs_val = 32'h5555_5555;
    #0.5;
    chk("R3 sequential next ignores instr/rs", pc_next, 32'h0000_0104);
    step();
    chk("R3 sequential step", pc_q, 32'h0000_0104);
    chk("R2 link value", link_val, 32'h0000_0108);
  endtask

  task automatic t_branch();
    set_pc(32'h0000_1000);
    pc_sel = 2'd1; instr = 32'h1000_0010;
    #0.5;
    chk("R4 forward branch", pc_next, 32'h0000_1044);
    instr = 32'h1000_FFFF;
    #0.5;
    chk("R4 backward one word", pc_next, 32'h0000_1000);
    set_pc(32'h0040_0000);
    pc_sel = 2'd1; instr = 32'h0000_8000;
    #0.5;
    chk("R4 most negative offset", pc_next, 32'h003E_0004);
    instr = 32'h0000_7FFF;
    #0.5;
    chk("R4 most positive offset", pc_next, 32'h0042_0000);
    step();
    chk("R4 branch taken into pc", pc_q, 32'h0042_0000);
  endtask

  task automatic t_region();
    set_pc(32'h3FFF_FFF8);
    pc_sel = 2'd3; instr = 32'h03FF_FFFF;
    #0.5;
    chk("R5 top of region 3", pc_next, 32'h3FFF_FFFC);
    set_pc(32'h0FFF_FFFC);
    pc_sel = 2'd3; instr = 32'hFC00_0000;
    #0.5;
    chk("R5 region from current pc, opcode ignored", pc_next, 32'h0000_0000);
    set_pc(32'hF000_0010);
    pc_sel = 2'd3; instr = 32'h0923_4567;
    #0.5;
    chk("R5 top region", pc_next, 32'hF48D_159C);
    step();
    chk("R5 jump into pc", pc_q, 32'hF48D_159C);
  endtask

  task automatic t_indirect();
    set_pc(32'h1234_5677);
    chk("R6 low bits kept", pc_q[1:0], 32'h3);
    chk("R2 link from odd pc", link_val, 32'h1234_567B);
  endtask

  task automatic t_hold();
    set_pc(32'h0000_2000);
    en = 1'b0; pc_sel = 2'd3; instr = 32'h0000_1234;
    step(); step(); step();
    chk("R7 hold with enable low", pc_q, 32'h0000_2000);
    chk("R7 next still formed", pc_next, 32'h0000_48D0);
    en = 1'b1;
    step();
    chk("R7 update on enable", pc_q, 32'h0000_48D0);
  endtask

  task automatic t_wrap();
    set_pc(32'hFFFF_FFFC);
    chk("R8 link wraps", link_val, 32'h0);
    pc_sel = 2'd0;
    step();
    chk("R8 sequential wraps", pc_q, 32'h0);
    set_pc(32'hFFFF_FFF0);
    pc_sel = 2'd1; instr = 32'h0000_0008;
    #0.5;
    chk("R8 branch wraps", pc_next, 32'h0000_0014);
    set_pc(32'h0000_0000);
    pc_sel = 2'd1; instr = 32'h0000_FFFE;
    #0.5;
    chk("R8 backward branch wraps", pc_next, 32'hFFFF_FFFC);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_branch();
    t_region();
    t_indirect();
    t_hold();
    t_wrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule